// File: doc/BRIEF.md
# DMA Bus-Master Ownership Controller

This block is the system-side master of a DMA engine. When software issues a start command, it requests the system bus through a request/grant handshake. Once the bus is granted, it runs one bus transfer per element of the programmed length. Each transfer walks through a fixed set of cycle states: an optional address-setup state, three active states, any wait states the ready input asks for, and a closing state.

The block decides three things at the end of every transfer:

- Whether the bus must be handed back because another master asked for it.
- Whether a failed transfer is repeated from a retry budget, or whether DMA halts with a sticky error.
- Whether the next transfer needs the extra address-setup state.

The release-request and bus-error inputs come from outside the bus clock domain. Each passes through a two-flop synchronizer before the sequencer acts on it.

There is no streaming data path in this block. Every pin is a plain control or status level, and none of them has back-pressure.

Top module: `dma_bus_owner`

## Requirements
- R1: While the bus is not owned (states IDLE and REQ), a low level on `rel_req_n` has no effect. The request is kept and the block still takes the bus on grant.
- R2: A release request seen while the bus is owned lets the transfer in progress reach its closing state C4. The bus is then dropped (state REL) before any new transfer starts. The block then re-requests the bus and finishes the remaining length.
- R3: `bus_req` is high only in state REQ. `bus_own` is high from the cycle after `bus_grant` is sampled high in REQ, and stays high until the end of state C4.
- R4: A synchronized bus error seen in C1, C2, C3 or CW sends the sequencer to C4 on the next clock, whatever the level of `ready`.
- R5: A failed transfer with a non-zero remaining retry count consumes one retry. It reissues the same address, entering through CX, and the address advances only on success.
- R6: A failed transfer with no retries left drops the bus and sets `err_halt`. The block then returns to IDLE and makes no further request.
- R7: A bus error outside states C1, C2, C3, CW and C4 is ignored.
- R8: In cycle-steal mode (`burst_mode` = 0 at start), every transfer begins with CX.
- R9: In burst mode, CX precedes only the first transfer after the bus is gained, any retried transfer, and any transfer whose address increment carried out of the low CARRY_W (16) bits.
- R10: `rel_req_n` and `bus_err_n` are active low and are sampled through two flops. A release asserted during C3 of a zero-wait transfer is therefore acted on only at the end of the following transfer.
- R11: `start` is taken only in IDLE. It loads the address, length and retry count, and clears `err_halt`. A start with zero length leaves the block idle, and a start while busy is ignored.
- R12: `cyc_state` encodes IDLE=0, REQ=1, CX=2, C1=3, C2=4, C3=5, CW=6, C4=7, REL=8. A low `ready` in C3 or CW holds the sequencer in CW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start command pulse |
| start_addr | input | AW | First transfer address |
| start_len | input | LW | Number of transfers |
| retry_limit | input | RW | Retry budget for bus errors |
| burst_mode | input | 1 | 1 = burst, 0 = cycle-steal, latched at start |
| bus_req | output | 1 | Bus request |
| bus_grant | input | 1 | Bus grant from arbiter |
| bus_own | output | 1 | Block currently drives the bus |
| rel_req_n | input | 1 | Asynchronous release request, active low |
| bus_err_n | input | 1 | Asynchronous bus error, active low |
| ready | input | 1 | Slave ready, ends wait states |
| cyc_state | output | 4 | Current cycle state code |
| addr_out | output | AW | Address of current transfer |
| busy | output | 1 | Block not idle |
| err_halt | output | 1 | Sticky halted-on-error flag |

## Verification
A corrupted retry count or error latch shows at the ports within one transfer. It appears either as an extra or missing C1 visit for the same `addr_out`, or as `err_halt` rising when it should stay low. A wrong carry or mode decision shows as a CX count that departs from the number of carry crossings, visible on `cyc_state` during the transfer that follows. A broken synchronizer depth or release deferral moves the `bus_own` falling edge by one whole transfer.

// File: rtl/dma_own_pkg.sv
package dma_own_pkg;
  typedef enum logic [3:0] {
    ST_IDLE = 4'd0,
    ST_REQ  = 4'd1,
    ST_CX   = 4'd2,
    ST_C1   = 4'd3,
    ST_C2   = 4'd4,
    ST_C3   = 4'd5,
    ST_CW   = 4'd6,
    ST_C4   = 4'd7,
    ST_REL  = 4'd8
  } cyc_st_e;
endpackage

// File: rtl/dma_sync.sv
module dma_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  input  logic [W-1:0] rst_val,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stg[i] <= rst_val;
        end else begin
          if (i == 0) stg[i] <= din;
          else        stg[i] <= stg[(i > 0) ? i-1 : 0];
        end
      end
    end
  endgenerate

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/dma_cnt.sv
module dma_cnt #(
  parameter int AW      = 24,
  parameter int LW      = 16,
  parameter int RW      = 4,
  parameter int CARRY_W = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] ld_addr,
  input  logic [LW-1:0] ld_len,
  input  logic [RW-1:0] ld_retry,
  input  logic          inc,
  input  logic          retry_dec,
  output logic [AW-1:0] addr,
  output logic          len_zero,
  output logic          len_one,
  output logic          retry_zero,
  output logic          carry_lo
);
  localparam logic [LW-1:0] LEN_ONE = LW'(1);

  logic [LW-1:0] len;
  logic [RW-1:0] retry;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr  <= '0;
      len   <= '0;
      retry <= '0;
    end else if (load) begin
      addr  <= ld_addr;
      len   <= ld_len;
      retry <= ld_retry;
    end else begin
      if (inc) begin
        addr <= addr + AW'(1);
        len  <= len - LEN_ONE;
      end
      if (retry_dec && retry != '0) retry <= retry - RW'(1);
    end
  end

  assign len_zero   = (len == '0);
  assign len_one    = (len == LEN_ONE);
  assign retry_zero = (retry == '0);
  assign carry_lo   = &addr[CARRY_W-1:0];

  // R5: the address moves by exactly one on each successful transfer
  p_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !load) |=> (addr == $past(addr) + AW'(1)));
endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_own_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  input  logic    start_len_zero,
  input  logic    burst_in,
  input  logic    grant,
  input  logic    rel_s,
  input  logic    err_s,
  input  logic    ready,
  input  logic    len_zero,
  input  logic    len_one,
  input  logic    retry_zero,
  input  logic    carry_lo,
  output cyc_st_e state,
  output logic    load,
  output logic    inc,
  output logic    retry_dec,
  output logic    failed,
  output logic    halt
);
  cyc_st_e nxt;
  logic    burst_r;
  logic    fail_r;
  logic    halt_set;
  logic    in_active;

  assign in_active = (state == ST_C1) || (state == ST_C2) ||
                     (state == ST_C3) || (state == ST_CW);
  assign load      = start && (state == ST_IDLE);
  assign failed    = (state == ST_C4) && (fail_r || err_s);

  always_comb begin
    nxt       = state;
    inc       = 1'b0;
    retry_dec = 1'b0;
    halt_set  = 1'b0;
    unique case (state)
      ST_IDLE: if (load && !start_len_zero) nxt = ST_REQ;
      ST_REQ:  if (grant) nxt = ST_CX;
      ST_CX:   nxt = ST_C1;
      ST_C1:   nxt = err_s ? ST_C4 : ST_C2;
      ST_C2:   nxt = err_s ? ST_C4 : ST_C3;
      ST_C3, ST_CW: nxt = (err_s || ready) ? ST_C4 : ST_CW;
      ST_C4: begin
        if (failed) begin
          if (retry_zero) begin
            halt_set = 1'b1;
            nxt      = ST_REL;
          end else begin
            retry_dec = 1'b1;
            nxt       = rel_s ? ST_REL : ST_CX;
          end
        end else begin
          inc = 1'b1;
          if (len_one || rel_s)         nxt = ST_REL;
          else if (!burst_r || carry_lo) nxt = ST_CX;
          else                           nxt = ST_C1;
        end
      end
      ST_REL:  nxt = (halt || len_zero) ? ST_IDLE : ST_REQ;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      burst_r <= 1'b0;
      fail_r  <= 1'b0;
      halt    <= 1'b0;
    end else begin
      state <= nxt;
      if (load) begin
        burst_r <= burst_in;
        halt    <= 1'b0;
      end else if (halt_set) begin
        halt <= 1'b1;
      end
      if (in_active && err_s)   fail_r <= 1'b1;
      else if (state == ST_C4)  fail_r <= 1'b0;
    end
  end

  // R4: a bus error in the late active states cuts straight to C4
  p_err_cut_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (err_s && (state == ST_C3 || state == ST_CW)) |=> (state == ST_C4));

  // R8: in cycle-steal mode every C1 is preceded by CX
  p_steal_tx_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_C1 && !burst_r) |-> ($past(state) == ST_CX));
endmodule

// File: rtl/dma_bus_owner.sv
module dma_bus_owner
  import dma_own_pkg::*;
#(
  parameter int AW      = 24,
  parameter int LW      = 16,
  parameter int RW      = 4,
  parameter int CARRY_W = 16,
  parameter int SYNC_N  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic [LW-1:0] start_len,
  input  logic [RW-1:0] retry_limit,
  input  logic          burst_mode,
  output logic          bus_req,
  input  logic          bus_grant,
  output logic          bus_own,
  input  logic          rel_req_n,
  input  logic          bus_err_n,
  input  logic          ready,
  output logic [3:0]    cyc_state,
  output logic [AW-1:0] addr_out,
  output logic          busy,
  output logic          err_halt
);
  cyc_st_e    state;
  logic [1:0] sync_q;
  logic       rel_s, err_s;
  logic       load, inc, retry_dec, failed;
  logic       len_zero, len_one, retry_zero, carry_lo;

  dma_sync #(.W(2), .STAGES(SYNC_N)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .din    ({bus_err_n, rel_req_n}),
    .rst_val(2'b11),
    .dout   (sync_q)
  );
  assign rel_s = ~sync_q[0];
  assign err_s = ~sync_q[1];

  dma_cnt #(.AW(AW), .LW(LW), .RW(RW), .CARRY_W(CARRY_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .ld_addr   (start_addr),
    .ld_len    (start_len),
    .ld_retry  (retry_limit),
    .inc       (inc),
    .retry_dec (retry_dec),
    .addr      (addr_out),
    .len_zero  (len_zero),
    .len_one   (len_one),
    .retry_zero(retry_zero),
    .carry_lo  (carry_lo)
  );

  dma_seq u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .start_len_zero(start_len == '0),
    .burst_in      (burst_mode),
    .grant         (bus_grant),
    .rel_s         (rel_s),
    .err_s         (err_s),
    .ready         (ready),
    .len_zero      (len_zero),
    .len_one       (len_one),
    .retry_zero    (retry_zero),
    .carry_lo      (carry_lo),
    .state         (state),
    .load          (load),
    .inc           (inc),
    .retry_dec     (retry_dec),
    .failed        (failed),
    .halt          (err_halt)
  );

  assign cyc_state = state;
  assign bus_req   = (state == ST_REQ);
  assign bus_own   = (state >= ST_CX) && (state <= ST_C4);
  assign busy      = (state != ST_IDLE);

  // R5: a failed transfer with retries left keeps its address
  p_retry_same_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_C4 && failed && !retry_zero) |=> (addr_out == $past(addr_out)));

  // R6: once halted and idle, no new bus request appears
  p_halt_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (err_halt && !busy && !start) |=> !bus_req);

  // R1: while waiting for grant, a release request does not move the sequencer
  p_rel_ignored_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_REQ && !bus_grant) |=> (state == ST_REQ));
endmodule

// File: tb/dma_bus_owner_bench.sv
module dma_bus_owner_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 24, LW = 16, RW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, burst_mode = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [LW-1:0] start_len = '0;
  logic [RW-1:0] retry_limit = '0;
  logic bus_req, bus_grant = 1'b0, bus_own;
  logic rel_req_n = 1'b1, bus_err_n = 1'b1, ready;
  logic [3:0] cyc_state;
  logic [AW-1:0] addr_out;
  logic busy, err_halt;

  int n_chk = 0, n_bad = 0;
  int c_tx, c_t1, c_tw, c_t4, own_falls, t4_first_fall;
  int wait_budget = 0, err_budget = 0;
  int rel_at = -1;
  logic err_on = 1'b0, rel_on = 1'b0, prev_own = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign ready = (wait_budget == 0);

  dma_bus_owner u_dma_bus_owner (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .start_len(start_len), .retry_limit(retry_limit), .burst_mode(burst_mode),
    .bus_req(bus_req), .bus_grant(bus_grant), .bus_own(bus_own),
    .rel_req_n(rel_req_n), .bus_err_n(bus_err_n), .ready(ready),
    .cyc_state(cyc_state), .addr_out(addr_out), .busy(busy), .err_halt(err_halt)
  );

  // Arbiter model and stimulus monitor
  always @(negedge clk) begin
    bus_grant <= bus_req;
    case (cyc_state)
      4'd2: c_tx++;
      4'd3: c_t1++;
      4'd6: c_tw++;
      4'd7: c_t4++;
      default: ;
    endcase
    if (prev_own && !bus_own) begin
      own_falls++;
      if (own_falls == 1) t4_first_fall = c_t4;
      if (rel_on) begin rel_req_n = 1'b1; rel_on = 1'b0; end
    end
    prev_own = bus_own;
    if ((cyc_state == 4'd5 || cyc_state == 4'd6) && wait_budget > 0) wait_budget--;
    if (err_budget > 0 && !err_on && cyc_state == 4'd3) begin
      bus_err_n = 1'b0; err_on = 1'b1; err_budget--;
    end else if (err_on && cyc_state == 4'd7) begin
      bus_err_n = 1'b1; err_on = 1'b0;
    end
    if (rel_at >= 0 && int'(cyc_state) == rel_at) begin
      rel_req_n = 1'b0; rel_on = 1'b1; rel_at = -1;
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_tally();
    c_tx = 0; c_t1 = 0; c_tw = 0; c_t4 = 0; own_falls = 0; t4_first_fall = -1;
  endtask

  task automatic run(input logic [AW-1:0] a, input int len, input int rty, input bit burst);
    clear_tally();
    @(negedge clk);
    start_addr = a; start_len = LW'(len); retry_limit = RW'(rty); burst_mode = burst;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (busy) @(negedge clk);
  endtask

  task automatic t_reset();
    check(cyc_state == 4'd0 && !bus_req && !bus_own && !busy && !err_halt,
          "R12 reset state idle", cyc_state, 0);
  endtask

  task automatic t_steal();
    clear_tally();
    @(negedge clk);
    start_addr = 24'h000100; start_len = 3; retry_limit = 0; burst_mode = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(bus_req && !bus_own && cyc_state == 4'd1, "R3 request after start", bus_req, 1);
    while (!bus_own) @(negedge clk);
    check(!bus_req && cyc_state == 4'd2, "R3 own after grant", cyc_state, 2);
    while (busy) @(negedge clk);
    check(c_tx == 3, "R8 CX on every transfer", c_tx, 3);
    check(c_t1 == 3 && c_tw == 0, "R12 three cycles no wait", c_t1, 3);
    check(addr_out == 24'h000103, "R8 final address", addr_out, 24'h000103);
  endtask

  task automatic t_burst();
    run(24'h00FFFE, 4, 0, 1'b1);
    check(c_tx == 2, "R9 CX on first and carry", c_tx, 2);
    check(c_t1 == 4, "R9 four transfers", c_t1, 4);
    check(addr_out == 24'h010002, "R9 final address", addr_out, 24'h010002);
    check(own_falls == 1, "R9 single tenure", own_falls, 1);
  endtask

  task automatic t_wait();
    wait_budget = 3;
    run(24'h000200, 1, 0, 1'b0);
    check(c_tw == 2, "R12 wait states while not ready", c_tw, 2);
    check(c_t4 == 1, "R12 one closing state", c_t4, 1);
  endtask

  task automatic t_release();
    rel_at = 4;
    run(24'h000300, 4, 0, 1'b0);
    check(t4_first_fall == 1, "R2 release after current cycle", t4_first_fall, 1);
    check(own_falls == 2, "R2 regained bus to finish", own_falls, 2);
    check(c_t4 == 4 && addr_out == 24'h000304, "R2 all transfers done", addr_out, 24'h000304);
  endtask

  task automatic t_sync_lat();
    rel_at = 5;
    run(24'h000400, 4, 0, 1'b0);
    check(t4_first_fall == 2, "R10 two-flop latency defers release", t4_first_fall, 2);
  endtask

  task automatic t_rel_idle();
    @(negedge clk);
    rel_req_n = 1'b0;
    repeat (6) @(negedge clk);
    check(!busy && !bus_req, "R1 release ignored while idle", busy, 0);
    rel_req_n = 1'b1;
    repeat (3) @(negedge clk);
    run(24'h000500, 2, 0, 1'b0);
    check(own_falls == 1 && c_t4 == 2, "R1 no extra release", own_falls, 1);
  endtask

  task automatic t_retry_ok();
    err_budget = 1;
    run(24'h000600, 1, 2, 1'b1);
    check(c_t1 == 2 && c_tx == 2, "R5 failed cycle reissued via CX", c_t1, 2);
    check(!err_halt, "R5 no halt with retries", err_halt, 0);
    check(addr_out == 24'h000601, "R5 address after retry", addr_out, 24'h000601);
  endtask

  task automatic t_halt();
    err_budget = 1;
    run(24'h000700, 3, 0, 1'b0);
    check(err_halt, "R6 halt flag set", err_halt, 1);
    check(c_t1 == 1 && addr_out == 24'h000700, "R6 no further transfers", c_t1, 1);
    check(c_tw == 0, "R4 error ends cycle without wait", c_tw, 0);
    repeat (4) @(negedge clk);
    check(!bus_req && !bus_own, "R6 no new request", bus_req, 0);
  endtask

  task automatic t_exhaust();
    err_budget = 2;
    run(24'h000800, 2, 1, 1'b0);
    check(err_halt && c_t1 == 2, "R6 halt after retries used", c_t1, 2);
  endtask

  task automatic t_err_wait();
    wait_budget = 50;
    err_budget = 1;
    run(24'h000850, 1, 0, 1'b0);
    check(err_halt && c_tw < 10, "R4 error overrides not ready", c_tw, 2);
    wait_budget = 0;
  endtask

  task automatic t_restart();
    check(err_halt, "R11 halt sticky before start", err_halt, 1);
    run(24'h000900, 1, 0, 1'b0);
    check(!err_halt && addr_out == 24'h000901, "R11 start clears halt", err_halt, 0);
  endtask

  task automatic t_err_idle();
    @(negedge clk);
    bus_err_n = 1'b0;
    repeat (5) @(negedge clk);
    bus_err_n = 1'b1;
    repeat (3) @(negedge clk);
    run(24'h000A00, 1, 0, 1'b0);
    check(!err_halt && c_t4 == 1, "R7 error outside cycle ignored", err_halt, 0);
  endtask

  task automatic t_start_rules();
    run(24'h000B00, 0, 0, 1'b0);
    check(!busy && c_t1 == 0, "R11 zero length stays idle", c_t1, 0);
    clear_tally();
    @(negedge clk);
    start_addr = 24'h000C00; start_len = 2; burst_mode = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    start_addr = 24'h00D000; start_len = 9; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (busy) @(negedge clk);
    check(c_t1 == 2 && addr_out == 24'h000C02, "R11 start while busy ignored", addr_out, 24'h000C02);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_steal();
    t_burst();
    t_wait();
    t_release();
    t_sync_lat();
    t_rel_idle();
    t_retry_ok();
    t_halt();
    t_restart();
    t_exhaust();
    t_err_wait();
    t_err_idle();
    t_start_rules();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule